// File: doc/BRIEF.md
# Converter Serial Port Controller

This block is the slave side of the serial link of a multichannel sampling converter. A host drives a serial clock and an active-low select. In every transfer the host sends the channel number for the next conversion. At the same time it reads back the result of the conversion before that. The block runs on a fast system clock. It oversamples the serial clock, the select and the data input through two-flop synchronizers. The select must hold a new level for a programmable number of system clocks before the block accepts the change.

After the tenth falling serial-clock edge of a frame, the block asks the converter core to start. The end-of-conversion line goes low until the core reports completion. When the select stays low between frames, the next frame starts in one of two ways. It starts when the conversion ends, or it starts on the sixteenth falling edge if the frame is longer than the conversion. When the select is toggled between frames, each frame may be 10 to 16 clocks long. The core and the analog selector are outside this block. The data output is modelled as a bit plus an output enable.

Top module: `cnv_serial_port`

## Requirements
- R1: While the accepted select level is high (`csNIn` inactive), `misoOe` is 0 and `misoOut` is 0. Serial clock and data-in activity starts no conversion and changes no state.
- R2: A select change is accepted only after the synchronized level has differed from the accepted level for `CS_QUAL_CYCLES` consecutive system clocks. A shorter pulse is ignored.
- R3: When a frame starts, `misoOut` shows bit 9 (MSB) of the stored result. Each serial falling edge moves to the next lower bit, so bit 0 appears after the 9th falling edge.
- R4: From the 10th falling edge until the frame ends, `misoOut` reads 0.
- R5: The channel number is taken MSB first from `mosiIn` on the first four serial rising edges. Later data-in bits in the frame are ignored. On the 10th falling edge the block pulses `convStart` for one system clock and presents the four bits on `convAddr`.
- R6: `eocOut` is high out of reset. It goes low on the 10th falling edge. It returns high on the system clock after `convDone` is seen, or on an abort.
- R7: If the select is held low and no serial rising edge follows the 10th falling edge before the conversion completes, a new frame starts at completion and shows the MSB of the new result.
- R8: If the select is held low and the 16th falling edge comes before completion, `misoOut` stays 0 until completion. A new frame showing the new result's MSB then starts.
- R9: If the 11th rising edge comes before completion, the frame continues with zeros to its 16th falling edge. A new frame showing the new result's MSB starts on that edge.
- R10: Suppose the select is released after the 10th falling edge and accepted low again before completion. The block then pulses `convAbort`, raises `eocOut`, and starts a frame that reads the previously stored result.
- R11: `syncLost` goes high when the select is released during a frame that was started by conversion completion and has seen 1 to 9 falling edges. Only an accepted select fall clears it.
- R12: After reset, `misoOe` is 0, `eocOut` is 1, `syncLost` is 0, `convStart` is 0, and the stored result is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rstN | input | 1 | Asynchronous active-low reset |
| sclkIn | input | 1 | Serial clock from the host, idle low |
| csNIn | input | 1 | Active-low select from the host |
| mosiIn | input | 1 | Serial data from host: channel number, MSB first |
| misoOut | output | 1 | Serial result bit to host |
| misoOe | output | 1 | High while the data output would be driven |
| eocOut | output | 1 | End of conversion, low while converting |
| convStart | output | 1 | One-clock pulse asking the core to convert |
| convAddr | output | ADDR_W | Channel number for the conversion |
| convAbort | output | 1 | One-clock pulse cancelling the running conversion |
| convDone | input | 1 | One-clock pulse from the core at completion |
| convResult | input | RES_W | Result from the core, valid with `convDone` |
| syncLost | output | 1 | Frame alignment with the host was lost |

## Verification
The bench builds the block with `CS_QUAL_CYCLES` set to 8 and leaves the other parameters at their defaults. With that setting, a select pulse that is too short, and the exact point where a long enough pulse is accepted, both fall within a few serial half-periods. A behavioural converter model with a delay that can be set per test drives the core handshake. Short and long delays reach each restart rule: completion-started, waiting after the 16th edge, and 16th-edge-started. The same model reaches the abort window and the late-clock case that loses alignment.

// File: rtl/cnv_port_pkg.sv
package cnv_port_pkg;

  // Strobes issued by the control FSM to the shift datapath.
  typedef struct packed {
    logic storeResult;     // capture converter result into the holding register
    logic loadFromCore;    // start a frame directly from the arriving result
    logic loadFromResult;  // start a frame from the holding register
    logic shiftOut;        // advance the outgoing result by one bit
    logic captureAddr;     // take one channel bit from the data input
    logic latchAddr;       // present captured channel to the converter
  } cnv_strobe_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,  // select released, port parked
    ST_SHIFT = 2'd1,  // frame running, before the handoff edge
    ST_TAIL  = 2'd2,  // after the handoff edge, trailing clocks
    ST_WAIT  = 2'd3   // long frame finished, waiting for completion
  } port_state_t;

endpackage

// File: rtl/cnv_port_sync.sv
module cnv_port_sync #(
  parameter int QUAL_CYCLES = 100
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclkIn,
  input  logic csNIn,
  input  logic dinIn,
  output logic sclkRise,
  output logic sclkFall,
  output logic dinBit,
  output logic csActive,
  output logic csFallStb,
  output logic csRiseStb
);

  localparam int QCNT_W = (QUAL_CYCLES < 2) ? 1 : $clog2(QUAL_CYCLES);
  localparam logic [QCNT_W-1:0] QLAST = QCNT_W'(QUAL_CYCLES - 1);

  logic [1:0]        sclkPipe;
  logic [1:0]        csPipe;
  logic [1:0]        dinPipe;
  logic              sclkPrev;
  logic              csQualN;
  logic [QCNT_W-1:0] qualCnt;
  logic              csDiffer;
  logic              qualDone;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPipe <= 2'b00;
      csPipe   <= 2'b11;
      dinPipe  <= 2'b00;
      sclkPrev <= 1'b0;
    end else begin
      sclkPipe <= {sclkPipe[0], sclkIn};
      csPipe   <= {csPipe[0], csNIn};
      dinPipe  <= {dinPipe[0], dinIn};
      sclkPrev <= sclkPipe[1];
    end
  end

  // Select qualification: the new level must persist for QUAL_CYCLES clocks.
  always_comb begin
    csDiffer = (csPipe[1] != csQualN);
    qualDone = csDiffer && (qualCnt == QLAST);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csQualN <= 1'b1;
      qualCnt <= '0;
    end else if (!csDiffer) begin
      qualCnt <= '0;
    end else if (qualDone) begin
      qualCnt <= '0;
      csQualN <= csPipe[1];
    end else begin
      qualCnt <= qualCnt + 1'b1;
    end
  end

  always_comb begin
    csFallStb = qualDone && !csPipe[1];
    csRiseStb = qualDone && csPipe[1];
    csActive  = !csQualN;
    sclkRise  = !csQualN && sclkPipe[1] && !sclkPrev;
    sclkFall  = !csQualN && !sclkPipe[1] && sclkPrev;
    dinBit    = dinPipe[1];
  end

endmodule

// File: rtl/cnv_port_data.sv
module cnv_port_data
  import cnv_port_pkg::*;
#(
  parameter int RES_W  = 10,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  cnv_strobe_t       stb,
  input  logic              dinBit,
  input  logic [RES_W-1:0]  convResult,
  output logic              misoBit,
  output logic [ADDR_W-1:0] convAddr
);

  logic [RES_W-1:0]  resultReg;
  logic [RES_W-1:0]  shiftReg;
  logic [ADDR_W-1:0] addrShift;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultReg <= '0;
      shiftReg  <= '0;
      addrShift <= '0;
      convAddr  <= '0;
    end else begin
      if (stb.storeResult) resultReg <= convResult;

      // A frame load wins over a shift in the same cycle; zeros fill behind
      // the result so the trailing clocks read low.
      if (stb.loadFromCore)        shiftReg <= convResult;
      else if (stb.loadFromResult) shiftReg <= resultReg;
      else if (stb.shiftOut)       shiftReg <= {shiftReg[RES_W-2:0], 1'b0};

      if (stb.captureAddr) addrShift <= {addrShift[ADDR_W-2:0], dinBit};
      if (stb.latchAddr)   convAddr  <= addrShift;
    end
  end

  assign misoBit = shiftReg[RES_W-1];

endmodule

// File: rtl/cnv_port_ctrl.sv
module cnv_port_ctrl
  import cnv_port_pkg::*;
#(
  parameter int RES_W      = 10,
  parameter int ADDR_W     = 4,
  parameter int FRAME_LONG = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclkRise,
  input  logic        sclkFall,
  input  logic        csFallStb,
  input  logic        csRiseStb,
  input  logic        convDone,
  output cnv_strobe_t stb,
  output logic        convBusy,
  output logic        convStart,
  output logic        convAbort,
  output logic        syncLost
);

  localparam int CNT_W = $clog2(FRAME_LONG + 1);
  localparam logic [CNT_W-1:0] HANDOFF_IDX = CNT_W'(RES_W - 1);
  localparam logic [CNT_W-1:0] LAST_IDX    = CNT_W'(FRAME_LONG - 1);
  localparam logic [CNT_W-1:0] ADDR_CNT    = CNT_W'(ADDR_W);

  port_state_t      state, nState;
  logic [CNT_W-1:0] fallCnt, nFall;
  logic [CNT_W-1:0] riseCnt, nRise;
  logic             extSeen, nExt;
  logic             fromEoc, nFromEoc;
  logic             nBusy, nStart, nAbort, nLost;
  logic             doneOk;

  always_comb begin
    nState   = state;
    nFall    = fallCnt;
    nRise    = riseCnt;
    nExt     = extSeen;
    nFromEoc = fromEoc;
    nBusy    = convBusy;
    nStart   = 1'b0;
    nAbort   = 1'b0;
    nLost    = syncLost;
    stb      = '0;
    doneOk   = convDone && convBusy;

    if (doneOk) begin
      nBusy           = 1'b0;
      stb.storeResult = 1'b1;
    end

    case (state)
      ST_SHIFT: begin
        if (sclkRise && (riseCnt < ADDR_CNT)) begin
          stb.captureAddr = 1'b1;
          nRise           = riseCnt + 1'b1;
        end
        if (sclkFall) begin
          stb.shiftOut = 1'b1;
          nFall        = fallCnt + 1'b1;
          if (fallCnt == HANDOFF_IDX) begin
            stb.latchAddr = 1'b1;
            nStart        = 1'b1;
            nBusy         = 1'b1;
            nExt          = 1'b0;
            nState        = ST_TAIL;
          end
        end
      end
      ST_TAIL: begin
        if (doneOk && !extSeen && !sclkRise) begin
          // No trailing clock seen: treat as a short frame, restart now.
          stb.loadFromCore = 1'b1;
          nState           = ST_SHIFT;
          nFall            = '0;
          nRise            = '0;
          nFromEoc         = 1'b1;
        end else begin
          if (sclkRise && convBusy) nExt = 1'b1;
          if (sclkFall) begin
            stb.shiftOut = 1'b1;
            nFall        = fallCnt + 1'b1;
            if (fallCnt == LAST_IDX) begin
              nFall    = '0;
              nRise    = '0;
              nFromEoc = 1'b0;
              if (convBusy && !doneOk) begin
                nState = ST_WAIT;
              end else begin
                nState = ST_SHIFT;
                if (doneOk) stb.loadFromCore   = 1'b1;
                else        stb.loadFromResult = 1'b1;
              end
            end
          end
        end
      end
      ST_WAIT: begin
        if (doneOk) begin
          stb.loadFromCore = 1'b1;
          nState           = ST_SHIFT;
          nFall            = '0;
          nRise            = '0;
          nFromEoc         = 1'b1;
        end
      end
      default: ;
    endcase

    if (csRiseStb) begin
      nState = ST_IDLE;
      if ((state == ST_SHIFT) && fromEoc && (fallCnt != '0)) nLost = 1'b1;
    end

    if (csFallStb) begin
      nState          = ST_SHIFT;
      nFall           = '0;
      nRise           = '0;
      nFromEoc        = 1'b0;
      nLost           = 1'b0;
      stb.shiftOut    = 1'b0;
      stb.captureAddr = 1'b0;
      stb.latchAddr   = 1'b0;
      stb.loadFromCore   = 1'b0;
      stb.loadFromResult = 1'b0;
      if (doneOk) begin
        stb.loadFromCore = 1'b1;
      end else begin
        stb.loadFromResult = 1'b1;
        if (convBusy) begin
          nAbort = 1'b1;
          nBusy  = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      fallCnt   <= '0;
      riseCnt   <= '0;
      extSeen   <= 1'b0;
      fromEoc   <= 1'b0;
      convBusy  <= 1'b0;
      convStart <= 1'b0;
      convAbort <= 1'b0;
      syncLost  <= 1'b0;
    end else begin
      state     <= nState;
      fallCnt   <= nFall;
      riseCnt   <= nRise;
      extSeen   <= nExt;
      fromEoc   <= nFromEoc;
      convBusy  <= nBusy;
      convStart <= nStart;
      convAbort <= nAbort;
      syncLost  <= nLost;
    end
  end

endmodule

// File: rtl/cnv_serial_port.sv
module cnv_serial_port
  import cnv_port_pkg::*;
#(
  parameter int RES_W          = 10,
  parameter int ADDR_W         = 4,
  parameter int FRAME_LONG     = 16,
  parameter int CS_QUAL_CYCLES = 100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclkIn,
  input  logic              csNIn,
  input  logic              mosiIn,
  output logic              misoOut,
  output logic              misoOe,
  output logic              eocOut,
  output logic              convStart,
  output logic [ADDR_W-1:0] convAddr,
  output logic              convAbort,
  input  logic              convDone,
  input  logic [RES_W-1:0]  convResult,
  output logic              syncLost
);

  cnv_strobe_t stb;
  logic sclkRise, sclkFall, dinBit, csActive, csFallStb, csRiseStb;
  logic misoBit, convBusy;

  cnv_port_sync #(.QUAL_CYCLES(CS_QUAL_CYCLES)) u_sync (
    .clk       (clk),
    .rstN      (rstN),
    .sclkIn    (sclkIn),
    .csNIn     (csNIn),
    .dinIn     (mosiIn),
    .sclkRise  (sclkRise),
    .sclkFall  (sclkFall),
    .dinBit    (dinBit),
    .csActive  (csActive),
    .csFallStb (csFallStb),
    .csRiseStb (csRiseStb)
  );

  cnv_port_ctrl #(.RES_W(RES_W), .ADDR_W(ADDR_W), .FRAME_LONG(FRAME_LONG)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .sclkRise  (sclkRise),
    .sclkFall  (sclkFall),
    .csFallStb (csFallStb),
    .csRiseStb (csRiseStb),
    .convDone  (convDone),
    .stb       (stb),
    .convBusy  (convBusy),
    .convStart (convStart),
    .convAbort (convAbort),
    .syncLost  (syncLost)
  );

  cnv_port_data #(.RES_W(RES_W), .ADDR_W(ADDR_W)) u_data (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .dinBit     (dinBit),
    .convResult (convResult),
    .misoBit    (misoBit),
    .convAddr   (convAddr)
  );

  assign misoOe  = csActive;
  assign misoOut = csActive & misoBit;
  assign eocOut  = ~convBusy;

endmodule

// File: rtl/cnv_serial_port_chk.sv
module cnv_serial_port_chk (
  input logic clk,
  input logic rstN,
  input logic csNIn,
  input logic misoOut,
  input logic misoOe,
  input logic eocOut,
  input logic convStart,
  input logic convAbort,
  input logic convDone,
  input logic syncLost
);

  assert_oe_needs_cs_low_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(misoOe) |-> !$past(csNIn, 3));

  assert_start_has_cs_R1: assert property (@(posedge clk) disable iff (!rstN)
    convStart |-> misoOe);

  assert_busy_reads_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    (misoOe && !eocOut) |-> !misoOut);

  assert_start_drops_eoc_R6: assert property (@(posedge clk) disable iff (!rstN)
    convStart |-> !eocOut);

  assert_eoc_rise_cause_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(eocOut) |-> ($past(convDone) || convAbort));

  assert_start_single_R5: assert property (@(posedge clk) disable iff (!rstN)
    convStart |=> !convStart);

  assert_abort_needs_conv_R10: assert property (@(posedge clk) disable iff (!rstN)
    convAbort |-> !$past(eocOut));

  assert_lost_on_release_R11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(syncLost) |-> !misoOe);

endmodule

bind cnv_serial_port cnv_serial_port_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .csNIn     (csNIn),
  .misoOut   (misoOut),
  .misoOe    (misoOe),
  .eocOut    (eocOut),
  .convStart (convStart),
  .convAbort (convAbort),
  .convDone  (convDone),
  .syncLost  (syncLost)
);

// File: tb/cnv_serial_port_bench.sv
`timescale 1ns/1ps
module cnv_serial_port_bench;

  localparam int QUAL = 8;
  localparam int H    = 6;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sclkIn = 1'b0;
  logic       csNIn = 1'b1;
  logic       mosiIn = 1'b0;
  logic       misoOut, misoOe, eocOut, convStart, convAbort, syncLost;
  logic [3:0] convAddr;
  logic       convDone;
  logic [9:0] convResult;

  int checks = 0;
  int errors = 0;
  int startCount = 0;
  int abortCount = 0;
  logic [3:0] lastAddr = '0;
  int convDelay = 50;
  logic [9:0] nextResult = '0;

  always #10 clk = ~clk;

  cnv_serial_port #(.CS_QUAL_CYCLES(QUAL)) u_cnv_serial_port (
    .clk        (clk),
    .rstN       (rstN),
    .sclkIn     (sclkIn),
    .csNIn      (csNIn),
    .mosiIn     (mosiIn),
    .misoOut    (misoOut),
    .misoOe     (misoOe),
    .eocOut     (eocOut),
    .convStart  (convStart),
    .convAddr   (convAddr),
    .convAbort  (convAbort),
    .convDone   (convDone),
    .convResult (convResult),
    .syncLost   (syncLost)
  );

  // Behavioural converter core.
  initial begin
    automatic bit pending = 0;
    automatic int waitCnt = 0;
    convDone = 1'b0;
    convResult = '0;
    forever begin
      @(negedge clk);
      convDone = 1'b0;
      if (convAbort) begin
        abortCount++;
        pending = 0;
      end
      if (pending) begin
        if (waitCnt == 0) begin
          convDone = 1'b1;
          convResult = nextResult;
          pending = 0;
        end else waitCnt--;
      end
      if (convStart) begin
        startCount++;
        lastAddr = convAddr;
        pending = 1;
        waitCnt = convDelay;
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic csAssert();
    csNIn = 1'b0;
    tick(QUAL + 6);
  endtask

  task automatic csRelease();
    csNIn = 1'b1;
    tick(QUAL + 6);
  endtask

  task automatic clockBit(input logic b);
    mosiIn = b;
    tick(H);
    sclkIn = 1'b1;
    tick(H);
    sclkIn = 1'b0;
    tick(H);
  endtask

  // Runs nClk clocks, sending addr then ones, checking each result bit.
  task automatic frameRun(input logic [9:0] expv, input logic [3:0] addr,
                          input int nClk, input string req);
    check(req, 16'(misoOut), 16'(expv[9]));
    for (int k = 1; k <= nClk; k++) begin
      clockBit(k <= 4 ? addr[4-k] : 1'b1);
      if (k < 10)      check(req, 16'(misoOut), 16'(expv[9-k]));
      else if (k < 16) check("R4 zero fill", 16'(misoOut), 16'h0);
    end
  endtask

  task automatic testReset();
    check("R12 oe", 16'(misoOe), 16'h0);
    check("R12 eoc", 16'(eocOut), 16'h1);
    check("R12 lost", 16'(syncLost), 16'h0);
    check("R12 start", 16'(convStart), 16'h0);
  endtask

  task automatic testGlitch();
    csNIn = 1'b0;
    tick(QUAL / 2);
    csNIn = 1'b1;
    tick(QUAL + 6);
    check("R2 short pulse ignored", 16'(misoOe), 16'h0);
    csNIn = 1'b0;
    tick(QUAL - 2);
    check("R2 not yet accepted", 16'(misoOe), 16'h0);
    tick(8);
    check("R2 accepted", 16'(misoOe), 16'h1);
  endtask

  task automatic testFirstFrame();
    automatic int s0 = startCount;
    nextResult = 10'h2D5;
    convDelay = 200;
    frameRun(10'h000, 4'h3, 10, "R12 zero result");
    check("R5 start count", 16'(startCount), 16'(s0 + 1));
    check("R5 address", 16'(lastAddr), 16'h3);
    check("R6 eoc low", 16'(eocOut), 16'h0);
    csRelease();
    tick(220);
    check("R6 eoc high", 16'(eocOut), 16'h1);
  endtask

  task automatic testIdleIgnore();
    automatic int s0 = startCount;
    for (int i = 0; i < 12; i++) clockBit(1'b1);
    check("R1 no start", 16'(startCount), 16'(s0));
    check("R1 oe", 16'(misoOe), 16'h0);
    check("R1 out", 16'(misoOut), 16'h0);
  endtask

  task automatic testLongToggled();
    csAssert();
    nextResult = 10'h1C3;
    convDelay = 300;
    frameRun(10'h2D5, 4'hA, 16, "R3 bit order");
    check("R5 address A", 16'(lastAddr), 16'hA);
    csRelease();
    tick(320);
  endtask

  task automatic testHeldLow10();
    csAssert();
    nextResult = 10'h27E;
    convDelay = 40;
    frameRun(10'h1C3, 4'h5, 10, "R3 frame");
    tick(60);
    check("R7 restart msb", 16'(misoOut), 16'h1);
    check("R7 eoc", 16'(eocOut), 16'h1);
    nextResult = 10'h30F;
    frameRun(10'h27E, 4'h6, 10, "R7 second frame");
    check("R7 tail low", 16'(misoOut), 16'h0);
    tick(60);
    check("R7 restart msb 2", 16'(misoOut), 16'h1);
    csRelease();
    check("R11 not lost", 16'(syncLost), 16'h0);
  endtask

  task automatic testShort16();
    csAssert();
    nextResult = 10'h200;
    convDelay = 400;
    frameRun(10'h30F, 4'h7, 16, "R8 frame");
    check("R8 wait low", 16'(misoOut), 16'h0);
    check("R8 eoc low", 16'(eocOut), 16'h0);
    tick(420);
    check("R8 msb at done", 16'(misoOut), 16'h1);
    check("R8 eoc high", 16'(eocOut), 16'h1);
  endtask

  task automatic testLong16();
    nextResult = 10'h355;
    convDelay = 30;
    frameRun(10'h200, 4'h8, 16, "R9 frame");
    check("R9 msb at 16th", 16'(misoOut), 16'h1);
    check("R9 eoc", 16'(eocOut), 16'h1);
    csRelease();
  endtask

  task automatic testAbort();
    automatic int a0 = abortCount;
    csAssert();
    nextResult = 10'h0AA;
    convDelay = 500;
    frameRun(10'h355, 4'h1, 10, "R10 frame");
    csRelease();
    csAssert();
    check("R10 abort pulse", 16'(abortCount), 16'(a0 + 1));
    check("R10 eoc", 16'(eocOut), 16'h1);
    convDelay = 30;
    frameRun(10'h355, 4'h2, 10, "R10 previous result");
    csRelease();
    tick(60);
  endtask

  task automatic testSyncLost();
    csAssert();
    nextResult = 10'h111;
    convDelay = 30;
    frameRun(10'h0AA, 4'h3, 10, "R11 frame");
    tick(60);
    for (int i = 0; i < 3; i++) clockBit(1'b0);
    csRelease();
    check("R11 lost set", 16'(syncLost), 16'h1);
    csAssert();
    check("R11 lost cleared", 16'(syncLost), 16'h0);
    csRelease();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick(5);
    rstN = 1'b1;
    tick(5);
    testReset();
    testGlitch();
    testFirstFrame();
    testIdleIgnore();
    testLongToggled();
    testHeldLow10();
    testShort16();
    testLong16();
    testAbort();
    testSyncLost();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule